// File: doc/BRIEF.md
# Transport Stream Packet Synchronizer

This block sits after a byte decoder on a serial video transport link and finds the packet structure in the stream of decoded bytes. It watches for the transport-stream sync byte 0x47 and counts the valid bytes that follow it. It then checks whether the next sync byte arrives exactly one packet length later. Both the 188-byte and the 204-byte packet lengths are accepted. The stream locks to whichever length is seen first, and the status word reports that length.

Each input byte comes out again one clock later, together with an 8-bit status word. The status word carries valid, start of packet, end of packet, error, the lock code, the line polarity and a per-byte decode-good flag. Downstream logic uses start and end of packet to frame packets, and uses the lock field to decide whether to trust the framing.

Top module: `ts_pkt_sync`

## Requirements
- R1: While `rst_n` is low, `out_data` and `out_stat` are all zeros and the block is unlocked and hunting.
- R2: Every clock, `out_data` equals the `in_data` of the previous cycle. `out_stat[0]` equals the previous `in_vld` and `out_stat[6]` equals the previous `in_pol`.
- R3: `out_stat[7]` is 1 exactly when the previous cycle had `in_vld` and `in_ok` both high, whatever the packet state.
- R4: A byte with `in_vld` low is not counted and cannot start, end or break a packet. For such a byte, `out_stat[3:1]` and `out_stat[7]` are 0, even if the byte is 0x47.
- R5: While hunting, the first valid 0x47 byte sets `out_stat[1]` (start of packet) and starts the byte count. That sync byte is byte 1 of the packet.
- R6: While unlocked, a valid 0x47 arriving exactly 188 valid bytes after the counted sync byte sets `out_stat[1]` and sets the lock field `out_stat[5:4]` to 2'b11.
- R7: While unlocked, if no sync byte came at 188, a valid 0x47 arriving exactly 204 valid bytes after the sync byte sets `out_stat[1]` and sets `out_stat[5:4]` to 2'b01.
- R8: While locked to length L, `out_stat[2]` (end of packet) marks the L-th valid byte of each packet, which is the byte just before the expected next sync.
- R9: While unlocked, if the valid byte at the 204-byte position is not 0x47, `out_stat[3]` (error) is set and hunting restarts. The next 0x47 then gives a start of packet.
- R10: While locked, if the valid byte at the locked position is not 0x47, `out_stat[3]` is set and `out_stat[5:4]` reads 2'b00 on that same byte.
- R11: A valid 0x47 at any other position inside a packet is treated as data: it gives no start of packet and does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Decoded byte |
| in_vld | input | 1 | Byte valid strobe |
| in_pol | input | 1 | Serial polarity indication |
| in_ok | input | 1 | Byte decoded without a code error |
| out_data | output | 8 | Byte delayed by one clock |
| out_stat | output | 8 | Status aligned with out_data: [0] valid, [1] start, [2] end, [3] error, [5:4] lock code (00 none, 01 for 204, 11 for 188), [6] polarity, [7] decode good |

## Verification
Two pairs of functions can fall on the same byte. A missing sync at the locked position raises the error and drops the lock field to 00 on that one byte. A sync at the 188- or 204-byte distance both marks start of packet and moves the lock field away from 00. The bench provokes the first by sending a non-sync byte at the boundary after several locked packets. It provokes the second at the first on-time repeat of a sync byte, in both the 188-byte and the 204-byte stream. A behavioural model, updated on every clock, judges each status field in that cycle. A checker also requires that an error never shows a lock and that any move out of 00 comes with start of packet.

// File: rtl/ts_pkt_sync.sv
module ts_pkt_sync #(
  parameter logic [7:0] SYNC_BYTE = 8'h47,
  parameter int         SHORT_LEN = 188,
  parameter int         LONG_LEN  = 204
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_vld,
  input  logic       in_pol,
  input  logic       in_ok,
  output logic [7:0] out_data,
  output logic [7:0] out_stat
);
  localparam int CW = $clog2(LONG_LEN + 1);
  localparam logic [CW-1:0] S_LEN = CW'(SHORT_LEN);
  localparam logic [CW-1:0] L_LEN = CW'(LONG_LEN);
  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [1:0] LK_NONE  = 2'b00;
  localparam logic [1:0] LK_LONG  = 2'b01;
  localparam logic [1:0] LK_SHORT = 2'b11;

  logic [CW-1:0] cnt, cnt_n;
  logic          have, have_n;
  logic [1:0]    lock, lock_n;
  logic          sop, eop, err;

  wire           is_sync = (in_data == SYNC_BYTE);
  wire [CW-1:0]  cur_len = (lock == LK_SHORT) ? S_LEN : L_LEN;

  always_comb begin
    cnt_n  = cnt;
    have_n = have;
    lock_n = lock;
    sop    = 1'b0;
    eop    = 1'b0;
    err    = 1'b0;
    if (in_vld) begin
      if (lock != LK_NONE) begin
        if (cnt == cur_len) begin
          if (is_sync) begin
            sop   = 1'b1;
            cnt_n = ONE;
          end else begin
            err    = 1'b1;
            lock_n = LK_NONE;
            have_n = 1'b0;
            cnt_n  = '0;
          end
        end else begin
          eop   = (cnt == cur_len - ONE);
          cnt_n = cnt + ONE;
        end
      end else if (have) begin
        if (cnt == S_LEN && is_sync) begin
          sop    = 1'b1;
          lock_n = LK_SHORT;
          cnt_n  = ONE;
        end else if (cnt == L_LEN) begin
          if (is_sync) begin
            sop    = 1'b1;
            lock_n = LK_LONG;
            cnt_n  = ONE;
          end else begin
            err    = 1'b1;
            have_n = 1'b0;
            cnt_n  = '0;
          end
        end else begin
          cnt_n = cnt + ONE;
        end
      end else if (is_sync) begin
        sop    = 1'b1;
        have_n = 1'b1;
        cnt_n  = ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      have     <= 1'b0;
      lock     <= LK_NONE;
      out_data <= '0;
      out_stat <= '0;
    end else begin
      cnt      <= cnt_n;
      have     <= have_n;
      lock     <= lock_n;
      out_data <= in_data;
      out_stat <= {in_vld & in_ok, in_pol, lock_n, err, eop, sop, in_vld};
    end
  end
endmodule

module ts_pkt_sync_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] in_data,
  input logic       in_pol,
  input logic [7:0] out_data,
  input logic [7:0] out_stat
);
  // R2
  data_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_data == $past(in_data));
  // R2
  pol_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_stat[6] == $past(in_pol));
  // R4
  idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_stat[0] |-> (out_stat[3:1] == 3'b000 && !out_stat[7]));
  // R10
  err_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_stat[3] |-> out_stat[5:4] == 2'b00);
  // R6
  acquire_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stat[5:4] != 2'b00 && $past(out_stat[5:4]) == 2'b00) |-> out_stat[1]);
  // R5
  sop_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_stat[1] && out_stat[3]));
  // R6
  lock_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_stat[5:4] != 2'b10);
endmodule

bind ts_pkt_sync ts_pkt_sync_chk u_chk (.*);

// File: tb/sim_ts_pkt_sync.sv
module sim_ts_pkt_sync;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic in_vld = 1'b0, in_pol = 1'b0, in_ok = 1'b0;
  logic [7:0] out_data, out_stat;

  ts_pkt_sync u0 (.clk, .rst_n, .in_data, .in_vld, .in_pol, .in_ok, .out_data, .out_stat);

  always #5 clk = ~clk;

  int errors = 0, checks = 0, tick = 0;
  bit done = 1'b0;

  // reference model state
  int m_cnt = 0, m_lock = 0;
  bit m_have = 0;
  logic [7:0] e_data = '0, e_stat = '0;

  always @(posedge clk) begin
    bit s, e, r;
    logic [1:0] lc;
    s = 0; e = 0; r = 0;
    if (!rst_n) begin
      m_cnt = 0; m_lock = 0; m_have = 0;
      e_data = '0; e_stat = '0;
    end else begin
      if (in_vld) begin
        if (m_lock != 0) begin
          if (m_cnt == m_lock) begin
            if (in_data == 8'h47) begin s = 1; m_cnt = 1; end
            else begin r = 1; m_lock = 0; m_have = 0; m_cnt = 0; end
          end else begin
            e = (m_cnt == m_lock - 1);
            m_cnt++;
          end
        end else if (m_have) begin
          if (m_cnt == 188 && in_data == 8'h47) begin s = 1; m_lock = 188; m_cnt = 1; end
          else if (m_cnt == 204) begin
            if (in_data == 8'h47) begin s = 1; m_lock = 204; m_cnt = 1; end
            else begin r = 1; m_have = 0; m_cnt = 0; end
          end else m_cnt++;
        end else if (in_data == 8'h47) begin
          s = 1; m_have = 1; m_cnt = 1;
        end
      end
      lc = (m_lock == 188) ? 2'b11 : (m_lock == 204) ? 2'b01 : 2'b00;
      e_data = in_data;
      e_stat = {in_vld & in_ok, in_pol, lc, r, e, s, in_vld};
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at tick %0d: actual=%h expected=%h", tag, tick, act, exp);
    end
  endtask

  task automatic compare();
    if (!rst_n) begin
      chk(out_data, 8'h00, "R1 data");
      chk(out_stat, 8'h00, "R1 status");
    end else begin
      chk(out_data, e_data, "R2 data");
      chk({7'd0, out_stat[0]}, {7'd0, e_stat[0]}, "R2 valid");
      chk({7'd0, out_stat[6]}, {7'd0, e_stat[6]}, "R2 polarity");
      chk({7'd0, out_stat[7]}, {7'd0, e_stat[7]}, "R3 decode good");
      chk({7'd0, out_stat[1]}, {7'd0, e_stat[1]}, "R5 R11 start");
      chk({7'd0, out_stat[2]}, {7'd0, e_stat[2]}, "R8 end");
      chk({7'd0, out_stat[3]}, {7'd0, e_stat[3]}, "R9 R10 error");
      chk({6'd0, out_stat[5:4]}, {6'd0, e_stat[5:4]}, "R6 R7 R10 lock");
      if (!e_stat[0])
        chk({out_stat[7], 4'd0, out_stat[3:1]}, 8'h00, "R4 idle flags");
    end
  endtask

  task automatic send(input logic [7:0] b, input logic v);
    @(negedge clk);
    compare();
    tick++;
    in_data = b;
    in_vld  = v;
    in_ok   = (tick % 11) != 0;
    in_pol  = tick[4];
  endtask

  function automatic logic [7:0] pay(input int i);
    logic [7:0] x;
    x = 8'(i * 7 + 3);
    return (x == 8'h47) ? 8'h48 : x;
  endfunction

  task automatic pkt(input int len, input int at47);
    send(8'h47, 1'b1);
    for (int i = 1; i < len; i++) begin
      if (i % 37 == 0) send(8'h47, 1'b0);
      send((i == at47) ? 8'h47 : pay(i), 1'b1);
    end
  endtask

  initial begin
    repeat (3) send(8'h00, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) send(pay(i + 9), 1'b1);
    // R6 lock to 188, R8 end flags
    for (int k = 0; k < 4; k++) pkt(188, 0);
    // R10 missing sync while locked
    send(8'h11, 1'b1);
    for (int i = 0; i < 4; i++) send(pay(i), 1'b1);
    // R7 lock to 204 with in-packet 0x47 (R11)
    for (int k = 0; k < 4; k++) pkt(204, 50);
    send(8'h22, 1'b1);
    // R9 unlocked, no sync at 188 or 204
    pkt(230, 120);
    for (int i = 0; i < 3; i++) send(pay(i), 1'b1);
    // re-acquire after restart (R5)
    for (int k = 0; k < 3; k++) pkt(188, 100);
    send(8'h47, 1'b1);
    send(8'h00, 1'b0);
    send(8'h00, 1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule